// File: doc/BRIEF.md
# Mixed-Width Two-Clock Block RAM

This block is a small embedded memory with one write port and one read port. Each port runs on its own clock. Both ports work on one shared array of 576 bits. Each port takes its shape, depth by width, from a parameter. The write shape and the read shape may differ, so a word stored at one width comes back as slices or as concatenations at the other width.

Five shapes use 512 bits of the array: 512x1, 256x2, 128x4, 64x8 and 32x16. Any of these five may face any other of the five. Two wider shapes use the whole array: 64x9 and 32x18. These two may face only each other. In the wide shapes the ninth bit of each group is plain stored data. The block does not compute or check it. A shape pairing outside these rules stops elaboration with an error.

Reads are registered on the read clock. The read port returns old contents when the same clock drives both ports and both touch the same bits in the same cycle. Each clock domain releases the shared active-low asynchronous reset through its own synchronizer. The array itself is not reset.

Top module: `mixw_ram`

## Requirements
- R1: A write with `wen` high in a narrow shape (width 1, 2, 4, 8 or 16) stores data bit `l` of `wdata` at array bit `waddr*WR_W + l`, and changes exactly `WR_W` array bits.
- R2: A read in a narrow shape returns in `rdata` bit `l` the array bit `raddr*RD_W + l`. For example, a 16-bit word written and then read at width 1 comes out least-significant bit first as the read address increases.
- R3: In the wide shapes (width 9 or 18), 9-bit group `g` of a word at address `a` has group number `k = a*(W/9) + g`. Its bits 0 to 7 sit at array bits `k*8` to `k*8+7`. Its bit 8 sits at array bit `512 + k`. The same rule applies when writing and when reading.
- R4: `rdata` takes the addressed word on the first rising `rclk` edge at which `ren` is sampled high.
- R5: While `ren` is low, `rdata` holds its value, even when the array changes underneath it.
- R6: A cycle with `wen` low changes no array bit, whatever `waddr` and `wdata` are.
- R7: When both ports share one clock and a read overlaps the bits being written in the same cycle, the read returns the contents from before the write.
- R8: `rdata` is zero during reset. It stays zero after reset is released until the first read that the read domain accepts once its synchronizer has let it go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain through a synchronizer |
| wen | input | 1 | Write enable |
| waddr | input | log2(write depth) | Write word address |
| wdata | input | WR_W | Write data |
| ren | input | 1 | Read enable |
| raddr | input | log2(read depth) | Read word address |
| rdata | output | RD_W | Registered read data |

## Verification
A read issued at a falling `rclk` edge is sampled at the next rising edge. Its result is compared at the falling edge after that, which is half a read cycle after the single output register loads. A write takes effect at the rising `wclk` edge where it is sampled, so the bench updates its bit-level model at that edge. It does not start a dependent read until after that edge. The bench drives a same-cycle overlap on shared-clock pairings only. There it queues the value from the model as it stood before the write. The hold and no-write checks sample `rdata` one or more cycles after the stimulus. By then any wrongful change would already show.

// File: rtl/mixw_ram_pkg.sv
package mixw_ram_pkg;

  localparam int unsigned ARRAY_BITS = 576;
  localparam int unsigned BYTE_BITS  = 512;

  function automatic bit is_wide(int unsigned w);
    return (w == 9) || (w == 18);
  endfunction

  function automatic bit is_shape(int unsigned w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16) || is_wide(w);
  endfunction

  function automatic int unsigned depth_of(int unsigned w);
    if (is_wide(w)) return ARRAY_BITS / w;
    else if (w != 0) return BYTE_BITS / w;
    else return 1;
  endfunction

  // array position of lane 'lane' of word 'addr' for a port of width w
  function automatic int unsigned bit_loc(int unsigned addr, int unsigned lane, int unsigned w);
    int unsigned grp;
    int unsigned sub;
    if (is_wide(w)) begin
      grp = addr * (w / 9) + lane / 9;
      sub = lane % 9;
      if (sub == 8) return BYTE_BITS + grp;
      else return grp * 8 + sub;
    end
    return addr * w + lane;
  endfunction

endpackage

// File: rtl/mixw_ram_rst_sync.sv
module mixw_ram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/mixw_ram_wr_map.sv
module mixw_ram_wr_map
  import mixw_ram_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 5
) (
  input  logic [AW-1:0]         addr,
  input  logic [W-1:0]          data,
  output logic [ARRAY_BITS-1:0] mask,
  output logic [ARRAY_BITS-1:0] bits
);

  always_comb begin
    mask = '0;
    bits = '0;
    for (int l = 0; l < W; l++) begin
      mask[bit_loc(int'(addr), l, W)] = 1'b1;
      bits[bit_loc(int'(addr), l, W)] = data[l];
    end
  end

endmodule

// File: rtl/mixw_ram_rd_map.sv
module mixw_ram_rd_map
  import mixw_ram_pkg::*;
#(
  parameter int W  = 1,
  parameter int AW = 9
) (
  input  logic [AW-1:0]         addr,
  input  logic [ARRAY_BITS-1:0] array,
  output logic [W-1:0]          word
);

  always_comb begin
    word = '0;
    for (int l = 0; l < W; l++) begin
      word[l] = array[bit_loc(int'(addr), l, W)];
    end
  end

endmodule

// File: rtl/mixw_ram.sv
module mixw_ram
  import mixw_ram_pkg::*;
#(
  parameter  int WR_W = 16,
  parameter  int RD_W = 1,
  localparam int WAW  = $clog2(depth_of(WR_W)),
  localparam int RAW  = $clog2(depth_of(RD_W))
) (
  input  logic            wclk,
  input  logic            rclk,
  input  logic            rst_n,
  input  logic            wen,
  input  logic [WAW-1:0]  waddr,
  input  logic [WR_W-1:0] wdata,
  input  logic            ren,
  input  logic [RAW-1:0]  raddr,
  output logic [RD_W-1:0] rdata
);

  localparam bit LEGAL = is_shape(WR_W) && is_shape(RD_W) &&
                         (is_wide(WR_W) == is_wide(RD_W));

  if (!LEGAL) begin : g_bad_shape
    $error("mixw_ram: unsupported port shape pairing");
  end

  logic                  wr_ok;
  logic                  rd_ok;
  logic                  wr_fire;
  logic                  rd_fire;
  logic [ARRAY_BITS-1:0] wr_mask;
  logic [ARRAY_BITS-1:0] wr_bits;
  logic [ARRAY_BITS-1:0] mem_q;
  logic [ARRAY_BITS-1:0] mem_d;
  logic [RD_W-1:0]       rd_word;
  logic [RD_W-1:0]       rdata_q;
  logic [RD_W-1:0]       rdata_d;

  mixw_ram_rst_sync #(.STAGES(2)) u_wsync (
    .clk(wclk), .rst_n(rst_n), .rst_n_sync(wr_ok)
  );

  mixw_ram_rst_sync #(.STAGES(2)) u_rsync (
    .clk(rclk), .rst_n(rst_n), .rst_n_sync(rd_ok)
  );

  mixw_ram_wr_map #(.W(WR_W), .AW(WAW)) u_wmap (
    .addr(waddr), .data(wdata), .mask(wr_mask), .bits(wr_bits)
  );

  mixw_ram_rd_map #(.W(RD_W), .AW(RAW)) u_rmap (
    .addr(raddr), .array(mem_q), .word(rd_word)
  );

  // write side: merge new lanes into the array
  always_comb begin
    wr_fire = wen && wr_ok;
    mem_d   = (mem_q & ~wr_mask) | (wr_bits & wr_mask);
  end

  always_ff @(posedge wclk) begin
    if (wr_fire) mem_q <= mem_d;
  end

  // read side: one output register, enabled by ren
  always_comb begin
    rd_fire = ren && rd_ok;
    rdata_d = rd_fire ? rd_word : rdata_q;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/mixw_ram_chk.sv
module mixw_ram_chk
  import mixw_ram_pkg::*;
#(
  parameter int WR_W = 16,
  parameter int RD_W = 1
) (
  input logic                  wclk,
  input logic                  rclk,
  input logic                  rst_n,
  input logic                  wen,
  input logic                  ren,
  input logic                  wr_ok,
  input logic                  rd_ok,
  input logic [ARRAY_BITS-1:0] wr_mask,
  input logic [ARRAY_BITS-1:0] mem_q,
  input logic [RD_W-1:0]       rdata
);

  // R1
  write_lane_count_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen && wr_ok) |-> ($countones(wr_mask) == WR_W));

  // R6
  idle_write_keeps_array_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !(wen && wr_ok) |=> $stable(mem_q));

  // R5
  idle_read_holds_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !ren |=> $stable(rdata));

  // R8
  reset_zero_out_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_ok |-> (rdata == '0));

endmodule

bind mixw_ram mixw_ram_chk #(.WR_W(WR_W), .RD_W(RD_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen(wen), .ren(ren),
  .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_mask(wr_mask), .mem_q(mem_q), .rdata(rdata)
);

// File: tb/mixw_ram_tb.sv
module mixw_ram_pair #(
  parameter int WR_W     = 16,
  parameter int RD_W     = 1,
  parameter bit SAME_CLK = 1
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  output logic done,
  output int   n_chk,
  output int   n_err
);

  localparam bit WIDE = (WR_W % 9) == 0;
  localparam int WDEP = WIDE ? 576 / WR_W : 512 / WR_W;
  localparam int RDEP = WIDE ? 576 / RD_W : 512 / RD_W;
  localparam int WAW  = $clog2(WDEP);
  localparam int RAW  = $clog2(RDEP);

  logic            wclk, rclk;
  logic            wen, ren;
  logic [WAW-1:0]  waddr;
  logic [RAW-1:0]  raddr;
  logic [WR_W-1:0] wdata;
  logic [RD_W-1:0] rdata;
  logic [575:0]    refm;
  logic            pend;
  logic [RD_W-1:0] exp_q[$];
  string           tag_q[$];

  assign wclk = clk_a;
  assign rclk = SAME_CLK ? clk_a : clk_b;

  mixw_ram #(.WR_W(WR_W), .RD_W(RD_W)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen(wen), .waddr(waddr),
    .wdata(wdata), .ren(ren), .raddr(raddr), .rdata(rdata)
  );

  function automatic void model_put(int a, logic [WR_W-1:0] d);
    if (WIDE) begin
      for (int g = 0; g < WR_W / 9; g++) begin
        int k = a * (WR_W / 9) + g;
        for (int b = 0; b < 8; b++) refm[k*8+b] = d[g*9+b];
        refm[512+k] = d[g*9+8];
      end
    end else begin
      for (int l = 0; l < WR_W; l++) refm[a*WR_W+l] = d[l];
    end
  endfunction

  function automatic logic [RD_W-1:0] model_get(int a);
    logic [RD_W-1:0] r;
    r = '0;
    if (WIDE) begin
      for (int g = 0; g < RD_W / 9; g++) begin
        int k = a * (RD_W / 9) + g;
        for (int b = 0; b < 8; b++) r[g*9+b] = refm[k*8+b];
        r[g*9+8] = refm[512+k];
      end
    end else begin
      for (int l = 0; l < RD_W; l++) r[l] = refm[a*RD_W+l];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [RD_W-1:0] got, logic [RD_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s wr%0d/rd%0d got %h exp %h", tag, WR_W, RD_W, got, exp);
    end
  endtask

  task automatic do_write(int a, logic [WR_W-1:0] d);
    @(negedge wclk);
    wen = 1'b1; waddr = WAW'(a); wdata = d;
    @(posedge wclk);
    #1;
    wen = 1'b0;
    model_put(a, d);
  endtask

  task automatic do_read(int a, string tag);
    @(negedge rclk);
    ren = 1'b1; raddr = RAW'(a);
    exp_q.push_back(model_get(a));
    tag_q.push_back(tag);
    @(posedge rclk);
    #1;
    ren = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge rclk);
  endtask

  // monitor: result due at the falling edge after the sampling edge (R4)
  always @(posedge rclk) pend <= ren;

  always @(negedge rclk) begin
    if (pend && exp_q.size() != 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  initial begin
    string mt;
    logic [RD_W-1:0] held;
    done = 1'b0; n_chk = 0; n_err = 0;
    wen = 1'b0; ren = 1'b0; waddr = '0; raddr = '0; wdata = '0;
    refm = '0;
    mt = WIDE ? "R3 R4" : "R1 R2 R4";
    wait (rst_n === 1'b1);
    repeat (4) @(negedge rclk);
    repeat (4) @(negedge wclk);
    check("R8", rdata, '0);
    // fill every write word, then read every read word
    for (int a = 0; a < WDEP; a++) do_write(a, WR_W'($urandom()));
    for (int a = 0; a < RDEP; a++) do_read(a, mt);
    drain();
    // interleaved random traffic
    for (int i = 0; i < 40; i++) begin
      do_write(int'($urandom_range(WDEP - 1)), WR_W'($urandom()));
      do_read(int'($urandom_range(RDEP - 1)), mt);
    end
    drain();
    // R6: address and data presented with wen low
    @(negedge wclk);
    wen = 1'b0; waddr = '0; wdata = ~WR_W'(refm[WR_W-1:0]);
    @(posedge wclk);
    #1;
    for (int a = 0; a < RDEP && a < 4; a++) do_read(a, "R6");
    drain();
    // R5: output holds while ren is low and the word underneath changes
    do_read(0, "R4");
    drain();
    held = model_get(0);
    do_write(0, ~WR_W'(refm[WR_W-1:0]));
    repeat (3) @(negedge rclk);
    check("R5", rdata, held);
    // R7: same-cycle overlap on a shared clock returns old contents
    if (SAME_CLK) begin
      for (int i = 0; i < 4; i++) begin
        logic [WR_W-1:0] nd;
        nd = ~WR_W'(refm[WR_W-1:0]) ^ WR_W'(i);
        @(negedge wclk);
        wen = 1'b1; waddr = '0; wdata = nd;
        ren = 1'b1; raddr = '0;
        exp_q.push_back(model_get(0));
        tag_q.push_back("R7");
        @(posedge wclk);
        #1;
        wen = 1'b0; ren = 1'b0;
        model_put(0, nd);
      end
      drain();
      do_read(0, "R7");
      drain();
    end
    done = 1'b1;
  end

endmodule

module mixw_ram_tb;

  localparam int NP = 7;

  logic clk, clk_b, rst_n, wdog;
  logic [NP-1:0] done;
  int chk[NP];
  int err[NP];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  initial clk_b = 1'b0;
  always #3.5 clk_b = ~clk_b;

  initial begin
    rst_n = 1'b0;
    #40;
    rst_n = 1'b1;
  end

  initial begin
    wdog = 1'b0;
    #800000;
    wdog = 1'b1;
  end

  mixw_ram_pair #(.WR_W(16), .RD_W(1),  .SAME_CLK(1)) u_p0 (.clk_a(clk), .clk_b(clk_b), .rst_n(rst_n), .done(done[0]), .n_chk(chk[0]), .n_err(err[0]));
  mixw_ram_pair #(.WR_W(1),  .RD_W(16), .SAME_CLK(0)) u_p1 (.clk_a(clk), .clk_b(clk_b), .rst_n(rst_n), .done(done[1]), .n_chk(chk[1]), .n_err(err[1]));
  mixw_ram_pair #(.WR_W(4),  .RD_W(8),  .SAME_CLK(1)) u_p2 (.clk_a(clk), .clk_b(clk_b), .rst_n(rst_n), .done(done[2]), .n_chk(chk[2]), .n_err(err[2]));
  mixw_ram_pair #(.WR_W(8),  .RD_W(2),  .SAME_CLK(0)) u_p3 (.clk_a(clk), .clk_b(clk_b), .rst_n(rst_n), .done(done[3]), .n_chk(chk[3]), .n_err(err[3]));
  mixw_ram_pair #(.WR_W(18), .RD_W(9),  .SAME_CLK(1)) u_p4 (.clk_a(clk), .clk_b(clk_b), .rst_n(rst_n), .done(done[4]), .n_chk(chk[4]), .n_err(err[4]));
  mixw_ram_pair #(.WR_W(9),  .RD_W(18), .SAME_CLK(0)) u_p5 (.clk_a(clk), .clk_b(clk_b), .rst_n(rst_n), .done(done[5]), .n_chk(chk[5]), .n_err(err[5]));
  mixw_ram_pair #(.WR_W(2),  .RD_W(4),  .SAME_CLK(1)) u_p6 (.clk_a(clk), .clk_b(clk_b), .rst_n(rst_n), .done(done[6]), .n_chk(chk[6]), .n_err(err[6]));

  initial begin
    int tc, te;
    wait ((&done) || wdog);
    #10;
    tc = 0; te = 0;
    for (int i = 0; i < NP; i++) begin
      tc += chk[i];
      te += err[i];
    end
    if (wdog && !(&done)) begin
      tc++; te++;
      $display("FAIL watchdog: run hung, done=%b expected all ones", done);
    end
    $display("CHECKS %0d ERRORS %0d", tc, te);
    $finish;
  end

endmodule